// File: doc/BRIEF.md
# Accumulator Processor Core

A small multicycle processor built around an 8-bit accumulator, one 8-bit general register and a single zero flag. It reads byte-wide instructions from a 16-bit address space through a synchronous memory port. The same port carries data loads and stores. Peripherals sit at ordinary addresses and are reached with the normal load and store instructions.

Each instruction is one opcode byte. Five of them carry a 16-bit address in the two bytes that follow. A control state machine fetches the opcode. It then fetches the address bytes when the instruction needs them, and finishes with the memory access or the register update. Programs start at address 0 after reset. There are no interrupts, no stack and no subroutine calls.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_ni` is low and right after it rises, PC, accumulator, register and zero flag are 0. The first bus cycle presents address 0 with write enable low.
- R2: Read data returns one cycle after its address. An opcode byte at address A is presented in one cycle and address A+1 in the next. A one-byte instruction takes 2 cycles. An address-bearing instruction presents A, A+1, A+2, then a fourth address, and its operand address is low byte first.
- R3: Opcode bytes 0x00..0x0F encode, in order: no-op, load, store, copy AC to R, copy R to AC, jump, jump-if-zero, jump-if-nonzero, add, subtract, increment, clear, and, or, xor, not. Any byte with a nonzero upper nibble runs as a one-byte no-op.
- R4: Load (0x01) reads the byte at the given address into AC and takes 5 cycles. Its fourth cycle presents the operand address and its fifth presents A+3. Store (0x02) drives AC on the write data with write enable high for exactly the fourth cycle, at the given address.
- R5: Copy AC to R (0x03) and copy R to AC (0x04) move the 8-bit value unchanged.
- R6: Add, subtract (AC minus R), increment, and, or, xor and not write AC modulo 256. They set Z to 1 when the new AC is zero and to 0 otherwise.
- R7: Clear (0x0B) sets AC to 0 and Z to 1.
- R8: No-op, load, store, both copies and all jumps leave Z unchanged.
- R9: Jump (0x05) continues execution at the 16-bit address it carries. Its fourth cycle presents A+3.
- R10: Jump-if-zero (0x06) is taken only when Z=1, and jump-if-nonzero (0x07) only when Z=0. When not taken, execution continues at A+3.
- R11: Loads and stores reach every address in the 64K space, including peripheral addresses at the top of it, without any special instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory address for every bus cycle |
| mem_wdata_o | output | 8 | Write data (the accumulator) |
| mem_we_o | output | 1 | Write enable, high for one cycle per store |
| mem_rdata_i | input | 8 | Read data for the address of the previous cycle |

## Verification
The hardest situation to reach from the ports is one where the zero flag must survive a run of non-arithmetic instructions before a conditional jump reads it. A wrongly updated flag only becomes visible as a wrong fetch address several instructions later. The program sets Z through a subtraction or a wrapping add. It then places copies, no-ops, undefined opcodes and loads in between, and follows them with conditional jumps whose taken and not-taken paths lead to different addresses. A reference model predicts every bus cycle, so any divergence in flag, data or timing shows on the address or write lines at the cycle where it happens.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0, OP_LDAC = 4'h1, OP_STAC = 4'h2, OP_MVAC = 4'h3,
    OP_MOVR = 4'h4, OP_JUMP = 4'h5, OP_JMPZ = 4'h6, OP_JPNZ = 4'h7,
    OP_ADD  = 4'h8, OP_SUB  = 4'h9, OP_INAC = 4'hA, OP_CLAC = 4'hB,
    OP_AND  = 4'hC, OP_OR   = 4'hD, OP_XOR  = 4'hE, OP_NOT  = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_DEC   = 3'd1,
    ST_ALO   = 3'd2,
    ST_AHI   = 3'd3,
    ST_LOAD  = 3'd4
  } state_e;

  function automatic logic op_has_addr(op_e op);
    return op inside {OP_LDAC, OP_STAC, OP_JUMP, OP_JMPZ, OP_JPNZ};
  endfunction

  function automatic logic op_sets_z(op_e op);
    return op inside {OP_ADD, OP_SUB, OP_INAC, OP_CLAC, OP_AND, OP_OR, OP_XOR, OP_NOT};
  endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic [DATA_W-1:0] r_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ac_we_o,
  output logic              z_we_o
);

  always_comb begin
    res_o   = ac_i;
    ac_we_o = 1'b1;
    unique case (op_i)
      OP_ADD:  res_o = ac_i + r_i;
      OP_SUB:  res_o = ac_i - r_i;
      OP_INAC: res_o = ac_i + 1'b1;
      OP_CLAC: res_o = '0;
      OP_AND:  res_o = ac_i & r_i;
      OP_OR:   res_o = ac_i | r_i;
      OP_XOR:  res_o = ac_i ^ r_i;
      OP_NOT:  res_o = ~ac_i;
      OP_MOVR: res_o = r_i;
      default: ac_we_o = 1'b0;
    endcase
    z_we_o = op_sets_z(op_i);
  end

endmodule

// File: rtl/acc_cpu_regs.sv
`timescale 1ns/1ps
module acc_cpu_regs
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_en_i,
  input  op_e               exec_op_i,
  input  logic              load_en_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              z_o
);

  logic [DATA_W-1:0] ac_q, r_q, alu_res;
  logic              z_q, alu_ac_we, alu_z_we;

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (exec_op_i),
    .ac_i    (ac_q),
    .r_i     (r_q),
    .res_o   (alu_res),
    .ac_we_o (alu_ac_we),
    .z_we_o  (alu_z_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q <= '0;
      r_q  <= '0;
      z_q  <= 1'b0;
    end else begin
      if (load_en_i)                   ac_q <= load_data_i;
      else if (exec_en_i && alu_ac_we) ac_q <= alu_res;
      if (exec_en_i && exec_op_i == OP_MVAC) r_q <= ac_q;
      if (exec_en_i && alu_z_we)       z_q  <= (alu_res == '0);
    end
  end

  assign ac_o = ac_q;
  assign z_o  = z_q;

endmodule

// File: rtl/acc_cpu_ctrl.sv
`timescale 1ns/1ps
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic              z_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              exec_en_o,
  output op_e               exec_op_o,
  output logic              load_en_o,
  output state_e            state_o,
  output logic [ADDR_W-1:0] pc_o,
  output op_e               ir_o
);

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d, target;
  logic [DATA_W-1:0] lo_q, lo_d;
  op_e               ir_q, ir_d, op_now;

  // upper opcode bits nonzero -> treated as no-op
  assign op_now = (rdata_i[DATA_W-1:4] == '0) ? op_e'(rdata_i[3:0]) : OP_NOP;
  assign target = {rdata_i, lo_q};

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    lo_d      = lo_q;
    ir_d      = ir_q;
    addr_o    = pc_q;
    we_o      = 1'b0;
    exec_en_o = 1'b0;
    load_en_o = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        pc_d    = pc_q + 1'b1;
        state_d = ST_DEC;
      end
      ST_DEC: begin
        ir_d = op_now;
        if (op_has_addr(op_now)) begin
          pc_d    = pc_q + 1'b1;
          state_d = ST_ALO;
        end else begin
          exec_en_o = 1'b1;
          state_d   = ST_FETCH;
        end
      end
      ST_ALO: begin
        lo_d    = rdata_i;
        pc_d    = pc_q + 1'b1;
        state_d = ST_AHI;
      end
      ST_AHI: begin
        state_d = ST_FETCH;
        unique case (ir_q)
          OP_LDAC: begin
            addr_o  = target;
            state_d = ST_LOAD;
          end
          OP_STAC: begin
            addr_o = target;
            we_o   = 1'b1;
          end
          OP_JUMP: pc_d = target;
          OP_JMPZ: if (z_i)  pc_d = target;
          OP_JPNZ: if (!z_i) pc_d = target;
          default: ;
        endcase
      end
      ST_LOAD: begin
        load_en_o = 1'b1;
        state_d   = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      lo_q    <= '0;
      ir_q    <= OP_NOP;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      lo_q    <= lo_d;
      ir_q    <= ir_d;
    end
  end

  assign wdata_o   = ac_i;
  assign exec_op_o = op_now;
  assign state_o   = state_q;
  assign pc_o      = pc_q;
  assign ir_o      = ir_q;

endmodule

// File: rtl/acc_cpu_core.sv
`timescale 1ns/1ps
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [2*DATA_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  output logic                  mem_we_o,
  input  logic [DATA_W-1:0]     mem_rdata_i
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W-1:0] ac;
  logic              z;
  logic              exec_en, load_en;
  op_e               exec_op, ir;
  state_e            state;
  logic [ADDR_W-1:0] pc;

  acc_cpu_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rdata_i   (mem_rdata_i),
    .ac_i      (ac),
    .z_i       (z),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o),
    .we_o      (mem_we_o),
    .exec_en_o (exec_en),
    .exec_op_o (exec_op),
    .load_en_o (load_en),
    .state_o   (state),
    .pc_o      (pc),
    .ir_o      (ir)
  );

  acc_cpu_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exec_en_i   (exec_en),
    .exec_op_i   (exec_op),
    .load_en_i   (load_en),
    .load_data_i (mem_rdata_i),
    .ac_o        (ac),
    .z_o         (z)
  );

endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input state_e            state_i,
  input op_e               ir_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [DATA_W-1:0] ac_i,
  input logic              z_i,
  input logic              exec_en_i,
  input op_e               exec_op_i,
  input logic              load_en_i,
  input logic              mem_we_i,
  input logic [DATA_W-1:0] mem_rdata_i
);

  a_r1_state_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i inside {ST_FETCH, ST_DEC, ST_ALO, ST_AHI, ST_LOAD});

  a_r2_fetch_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FETCH |=> pc_i == $past(pc_i) + 1'b1);

  a_r4_we_only_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (state_i == ST_AHI && ir_i == OP_STAC));

  a_r4_we_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);

  a_r4_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> ac_i == $past(mem_rdata_i));

  a_r6_z_follows_ac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en_i && op_sets_z(exec_op_i)) |=> z_i == (ac_i == '0));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en_i && exec_op_i == OP_CLAC) |=> (ac_i == '0 && z_i));

  a_r8_z_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_en_i && op_sets_z(exec_op_i)) |=> $stable(z_i));

  a_r9_jump_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_AHI && ir_i == OP_JUMP) |=> pc_i[ADDR_W-1:DATA_W] == $past(mem_rdata_i));

  a_r10_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_AHI && ((ir_i == OP_JMPZ && !z_i) || (ir_i == OP_JPNZ && z_i)))
    |=> $stable(pc_i));

endmodule

bind acc_cpu_core acc_cpu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (state),
  .ir_i        (ir),
  .pc_i        (pc),
  .ac_i        (ac),
  .z_i         (z),
  .exec_en_i   (exec_en),
  .exec_op_i   (exec_op),
  .load_en_i   (load_en),
  .mem_we_i    (mem_we_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/tb_acc_cpu_core.sv
`timescale 1ns/1ps
module tb_acc_cpu_core;

  localparam int          MEM_N  = 4096;
  localparam logic [15:0] OUT_A  = 16'hFF00;
  localparam logic [15:0] IN_A   = 16'hFF01;
  localparam logic [7:0]  IN_VAL = 8'h6D;
  localparam logic [15:0] TRAP   = 16'h0FF0;
  localparam int          CYCLES = 3000;

  localparam logic [7:0] C_NOP = 8'h00, C_LDAC = 8'h01, C_STAC = 8'h02, C_MVAC = 8'h03,
                         C_MOVR = 8'h04, C_JUMP = 8'h05, C_JMPZ = 8'h06, C_JPNZ = 8'h07,
                         C_ADD = 8'h08, C_SUB = 8'h09, C_INAC = 8'h0A, C_CLAC = 8'h0B,
                         C_AND = 8'h0C, C_OR = 8'h0D, C_XOR = 8'h0E, C_NOT = 8'h0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr;
  logic [7:0]  wdata, rdata = 8'h00;
  logic        we;
  logic [7:0]  mem [MEM_N];
  logic [7:0]  out_port = 8'h00;

  always #2 clk = ~clk;

  acc_cpu_core dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (addr),
    .mem_wdata_o (wdata),
    .mem_we_o    (we),
    .mem_rdata_i (rdata)
  );

  always @(posedge clk) begin
    if (we) begin
      if (addr < MEM_N) mem[addr[11:0]] <= wdata;
      else if (addr == OUT_A) out_port <= wdata;
    end
    rdata <= (addr == IN_A) ? IN_VAL : (addr < MEM_N) ? mem[addr[11:0]] : 8'h00;
  end

  // reference model
  logic [7:0]  mm [MEM_N];
  logic [15:0] mpc = 16'h0;
  logic [7:0]  mac = 8'h0, mr = 8'h0, m_out = 8'h0;
  bit          mz = 1'b0;
  logic [15:0] qa[$];
  bit          qw[$];
  logic [7:0]  qd[$];
  string       qt[$];

  int n_chk = 0, n_fail = 0, pcb = 0;
  bit done = 1'b0;

  function automatic logic [7:0] mrd(logic [15:0] a);
    if (a == IN_A) return IN_VAL;
    if (a < MEM_N) return mm[a[11:0]];
    return 8'h00;
  endfunction

  function automatic void push(logic [15:0] a, bit w, logic [7:0] d, string t);
    qa.push_back(a); qw.push_back(w); qd.push_back(d); qt.push_back(t);
  endfunction

  function automatic void step();
    logic [7:0]  op, res;
    logic [15:0] t, nxt;
    string       tg;
    op = mrd(mpc);
    if (op inside {C_LDAC, C_STAC, C_JUMP, C_JMPZ, C_JPNZ}) begin
      t   = {mrd(mpc + 16'd2), mrd(mpc + 16'd1)};
      nxt = mpc + 16'd3;
      tg  = (op == C_JUMP) ? "R9" : (op == C_JMPZ || op == C_JPNZ) ? "R8/R10" :
            (t >= OUT_A) ? "R11" : "R4";
      push(mpc, 0, 0, tg); push(mpc + 16'd1, 0, 0, "R2"); push(mpc + 16'd2, 0, 0, "R2");
      case (op)
        C_LDAC: begin push(t, 0, 0, tg); push(mpc + 16'd3, 0, 0, tg); mac = mrd(t); end
        C_STAC: begin
          push(t, 1, mac, tg);
          if (t < MEM_N) mm[t[11:0]] = mac; else if (t == OUT_A) m_out = mac;
        end
        default: begin
          push(mpc + 16'd3, 0, 0, tg);
          if (op == C_JUMP || (op == C_JMPZ && mz) || (op == C_JPNZ && !mz)) nxt = t;
        end
      endcase
    end else begin
      nxt = mpc + 16'd1;
      tg  = (op[7:4] != 0 || op == C_NOP) ? "R3" : (op == C_MVAC || op == C_MOVR) ? "R5" :
            (op == C_CLAC) ? "R7" : "R6";
      push(mpc, 0, 0, tg); push(mpc + 16'd1, 0, 0, tg);
      res = mac;
      if (op[7:4] == 0) begin
        case (op)
          C_ADD:  res = mac + mr;
          C_SUB:  res = mac - mr;
          C_INAC: res = mac + 8'd1;
          C_CLAC: res = 8'd0;
          C_AND:  res = mac & mr;
          C_OR:   res = mac | mr;
          C_XOR:  res = mac ^ mr;
          C_NOT:  res = ~mac;
          C_MOVR: res = mr;
          C_MVAC: mr = mac;
          default: ;
        endcase
        if (op >= C_ADD) mz = (res == 8'd0);
      end
      mac = res;
    end
    mpc = nxt;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    mem[pcb] = b; mm[pcb] = b; pcb++;
  endtask

  task automatic put3(logic [7:0] op, logic [15:0] a);
    put(op); put(a[7:0]); put(a[15:8]);
  endtask

  task automatic patch(int loc, logic [15:0] a);
    mem[loc + 1] = a[7:0];  mm[loc + 1] = a[7:0];
    mem[loc + 2] = a[15:8]; mm[loc + 2] = a[15:8];
  endtask

  task automatic poke(int a, logic [7:0] v);
    mem[a] = v; mm[a] = v;
  endtask

  task automatic build();
    int lp, j1, end_a;
    for (int i = 0; i < MEM_N; i++) poke(i, 8'h00);
    poke('h202, 8'd22); poke('h203, 8'h3C); poke('h204, 8'hA5);
    poke('h206, 8'hFF); poke('h207, 8'h80);
    pcb = 'hFF0; put3(C_JUMP, TRAP);
    pcb = 0;
    put(C_CLAC); put3(C_STAC, 16'h200); put3(C_STAC, 16'h201);
    lp = pcb;
    put3(C_LDAC, 16'h201); put(C_INAC); put3(C_STAC, 16'h201); put(C_MVAC);
    put3(C_LDAC, 16'h200); put(C_ADD); put3(C_STAC, 16'h200);
    put3(C_LDAC, 16'h202); put(C_SUB); put3(C_JPNZ, lp[15:0]);
    put3(C_LDAC, 16'h204); put(C_MVAC); put3(C_LDAC, 16'h203);
    put(C_AND); put3(C_STAC, OUT_A);
    put3(C_LDAC, 16'h203); put(C_OR); put3(C_STAC, 16'h208);
    put(C_XOR); put3(C_STAC, 16'h209); put(C_NOT); put3(C_STAC, 16'h20A);
    put(C_MOVR); put3(C_STAC, 16'h20B); put(C_SUB);
    put(C_MVAC); put(C_NOP); put(8'h3A); put(8'h9F);
    j1 = pcb; put3(C_JMPZ, 16'h0);
    put(C_INAC);
    patch(j1, 16'(pcb));
    put3(C_JPNZ, TRAP); put3(C_LDAC, IN_A); put3(C_STAC, 16'h205);
    put3(C_LDAC, 16'h206); put(C_INAC); put3(C_STAC, 16'h20C); put3(C_JPNZ, TRAP);
    put3(C_LDAC, 16'h207); put(C_MVAC); put(C_ADD); put3(C_JPNZ, TRAP);
    put3(C_STAC, 16'h20D); put3(C_LDAC, 16'h204); put3(C_JPNZ, TRAP);
    put(C_INAC); put3(C_JMPZ, TRAP); put3(C_STAC, 16'h20E);
    end_a = pcb; put3(C_JUMP, 16'(end_a));
  endtask

  initial begin
    build();
    repeat (3) @(negedge clk);
    check(addr == 16'h0 && we == 1'b0, "R1", "addr/we in reset", {addr, 7'b0, we}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < CYCLES; c++) begin
      logic [15:0] ea;
      bit          ew;
      logic [7:0]  ed;
      string       et;
      if (qa.size() == 0) step();
      ea = qa.pop_front(); ew = qw.pop_front(); ed = qd.pop_front(); et = qt.pop_front();
      if (c == 0) et = "R1";
      check(addr == ea, et, "address", int'(addr), int'(ea));
      check(we == ew, et, "write enable", int'(we), int'(ew));
      if (ew) check(wdata == ed, et, "write data", int'(wdata), int'(ed));
      @(posedge clk);
      @(negedge clk);
    end
    check(mem['h200] == 8'd253, "R4", "sum 1..22", int'(mem['h200]), 253);
    for (int a = 'h200; a <= 'h20E; a++)
      check(mem[a] == mm[a], "R6", $sformatf("mem[%0h]", a), int'(mem[a]), int'(mm[a]));
    check(out_port == m_out, "R11", "output port", int'(out_port), int'(m_out));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule